// File: doc/BRIEF.md
# UART Receive Word Packer with Stale Flush

This block sits behind a UART receiver that delivers one 8-bit character per cycle on a valid/data strobe. It gathers consecutive characters into 32-bit words and queues each complete word in an eight-word receive FIFO. A host reaches the block through a small word-addressed register port. Reading the data register pops one word. Status bits report word availability, receive overrun and a stale indication. A separate fill register shows how many characters sit in the packing buffer that has not yet been released.

A partial word leaves the packing buffer only through a stale event. The host can force one with a command. The block also raises one itself when the buffer holds characters and sees no new character for a set number of cycles, or when a programmable receive transfer length has been reached. A flushed partial word carries zeros in its unused upper bytes. Host commands clear the overrun flag, clear the stale indication and reset the receive path.

Top module: `uart_rx_word_packer`

## Requirements
- R1: Characters are packed four to a word in arrival order: the first character of a word occupies bits [7:0], the second [15:8], the third [23:16] and the fourth [31:24]. A complete word enters the FIFO without host action.
- R2: The status register (address 1) bit 0 is 1 exactly when at least one word is waiting in the FIFO. A read of the data register (address 0) returns the oldest word and pops it. When the FIFO is empty, that read returns 0 and changes nothing.
- R3: The fill register (address 2) reports the packing-buffer character count, 0 to 4, in bits [9:7]. All its other bits read 0.
- R4: Writing 0x400 to the command register (address 3) forces a stale event. The partial buffer is pushed as one word with its unused upper bytes zero. A character that arrives in the same cycle as the command is included in that word. With an empty buffer, nothing is pushed.
- R5: When the buffer holds characters and no character arrives for STALE_TO consecutive cycles, a stale event is raised and the partial word is flushed.
- R6: The transfer-length register (address 4, 16 bits, read/write, reset 0) raises a stale event on the accepted character that brings the count since the last write of that register to its value. The count then restarts. A value of 0 disables this source.
- R7: Status bit 5 is set by any stale event and is cleared by writing 0x80 to the command register. A new stale event in the same cycle wins.
- R8: A character that arrives while the FIFO is full and the buffer already holds 4 characters is dropped, and status bit 4 (overrun) is set. Writing 0x30 to the command register clears it. The held word enters the FIFO as soon as a slot frees.
- R9: Writing 0x10 to the command register empties both the packing buffer and the FIFO. A character that arrives in the same cycle is discarded.
- R10: Any other value written to the command register has no effect.
- R11: The FIFO holds FIFO_DEPTH (default 8) words, and no word is lost or reordered while it is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received character strobe |
| rx_data_i | input | 8 | Received character |
| reg_we_i | input | 1 | Register write enable |
| reg_re_i | input | 1 | Register read enable (pops FIFO at address 0) |
| reg_addr_i | input | 3 | Word address of register |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from address) |

## Verification
Two collisions are the point of interest. The first is a character arriving in the same cycle as the force-stale command. The bench drives both on one clock edge and expects the flushed word to hold that character next to the older ones, with a zero fill count afterwards. The second is a FIFO pop that frees the slot the held full word is waiting for. The bench drives 37 back-to-back characters into a full FIFO and then drains it, expecting exactly the first 36 characters in order, with the 37th missing and the overrun flag set.

// File: rtl/uart_rx_pack_pkg.sv
`timescale 1ns/1ps
package uart_rx_pack_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_DATA = 3'd0,
    REG_STAT = 3'd1,
    REG_FILL = 3'd2,
    REG_CMD  = 3'd3,
    REG_XLEN = 3'd4
  } reg_sel_e;

  localparam logic [31:0] CMD_RX_RESET    = 32'h0000_0010;
  localparam logic [31:0] CMD_ERR_CLR     = 32'h0000_0030;
  localparam logic [31:0] CMD_STALE_CLR   = 32'h0000_0080;
  localparam logic [31:0] CMD_FORCE_STALE = 32'h0000_0400;

  localparam int unsigned ST_READY = 0;
  localparam int unsigned ST_OVR   = 4;
  localparam int unsigned ST_STALE = 5;
  localparam int unsigned FILL_LSB = 7;
endpackage

// File: rtl/rx_word_fifo.sv
`timescale 1ns/1ps
module rx_word_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [LW-1:0]    level_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [LW-1:0]    level_q;
  logic             do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (level_q == '0);
  assign full_o  = (level_q == LW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign level_o = level_q;
endmodule

// File: rtl/rx_pack_buf.sv
`timescale 1ns/1ps
module rx_pack_buf (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        byte_vld_i,
  input  logic [7:0]  byte_i,
  input  logic        stale_evt_i,
  input  logic        fifo_full_i,
  output logic        push_o,
  output logic [31:0] word_o,
  output logic [2:0]  cnt_o,
  output logic        byte_acc_o,
  output logic        drop_o
);
  logic [31:0] buf_q;
  logic [2:0]  cnt_q;
  logic        pend_q;
  logic        flush, held_full;

  // release a complete word, or a partial one once a stale event is pending
  assign flush     = !fifo_full_i && ((cnt_q == 3'd4) || (pend_q && cnt_q != 3'd0));
  assign held_full = (cnt_q == 3'd4) && !flush;
  assign byte_acc_o = byte_vld_i && !clr_i && !held_full;
  assign drop_o     = byte_vld_i && !clr_i && held_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (clr_i) begin
      buf_q  <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (flush) begin
        buf_q <= byte_acc_o ? {24'd0, byte_i} : 32'd0;
        cnt_q <= byte_acc_o ? 3'd1 : 3'd0;
      end else if (byte_acc_o) begin
        buf_q[{cnt_q[1:0], 3'b000} +: 8] <= byte_i;
        cnt_q <= cnt_q + 3'd1;
      end
      if (stale_evt_i)                                  pend_q <= 1'b1;
      else if (flush)                                   pend_q <= 1'b0;
      else if (cnt_q == 3'd0 && !byte_acc_o)            pend_q <= 1'b0;
    end
  end

  assign push_o = flush;
  assign word_o = buf_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/rx_stale_timer.sv
`timescale 1ns/1ps
module rx_stale_timer #(
  parameter int unsigned STALE_TO = 16,
  parameter int unsigned XLEN_W   = 16,
  localparam int unsigned IW = $clog2(STALE_TO + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              byte_acc_i,
  input  logic              nonempty_i,
  input  logic [XLEN_W-1:0] xlen_i,
  input  logic              xlen_wr_i,
  output logic              stale_evt_o
);
  logic [IW-1:0]     idle_q;
  logic [XLEN_W-1:0] xcnt_q;
  logic              tmo, len_hit;

  assign tmo     = nonempty_i && !byte_acc_i && (idle_q == IW'(STALE_TO - 1));
  assign len_hit = byte_acc_i && (xlen_i != '0) && ((xcnt_q + 1'b1) == xlen_i);
  assign stale_evt_o = tmo || len_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= '0;
      xcnt_q <= '0;
    end else begin
      if (clr_i || byte_acc_i || !nonempty_i || tmo) idle_q <= '0;
      else                                          idle_q <= idle_q + 1'b1;

      if (clr_i || xlen_wr_i || len_hit) xcnt_q <= '0;
      else if (byte_acc_i)              xcnt_q <= xcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_word_packer.sv
`timescale 1ns/1ps
module uart_rx_word_packer
  import uart_rx_pack_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned STALE_TO   = 16,
  parameter int unsigned XLEN_W     = 16,
  localparam int unsigned LW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  input  logic        reg_we_i,
  input  logic        reg_re_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o
);
  logic              cmd_wr, rx_clr, err_clr, stale_clr, force_stale, xlen_wr;
  logic              fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [31:0]       fifo_rdata, pack_word;
  logic [LW-1:0]     fifo_level;
  logic [2:0]        pack_cnt;
  logic              byte_acc, byte_drop, tmr_evt, stale_evt;
  logic              overrun_q, stale_q;
  logic [XLEN_W-1:0] xlen_q;

  assign cmd_wr      = reg_we_i && (reg_addr_i == REG_CMD);
  assign rx_clr      = cmd_wr && (reg_wdata_i == CMD_RX_RESET);
  assign err_clr     = cmd_wr && (reg_wdata_i == CMD_ERR_CLR);
  assign stale_clr   = cmd_wr && (reg_wdata_i == CMD_STALE_CLR);
  assign force_stale = cmd_wr && (reg_wdata_i == CMD_FORCE_STALE);
  assign xlen_wr     = reg_we_i && (reg_addr_i == REG_XLEN);
  assign stale_evt   = force_stale || tmr_evt;
  assign fifo_pop    = reg_re_i && (reg_addr_i == REG_DATA) && !fifo_empty;

  rx_pack_buf u_pack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (rx_clr),
    .byte_vld_i  (rx_valid_i),
    .byte_i      (rx_data_i),
    .stale_evt_i (stale_evt),
    .fifo_full_i (fifo_full),
    .push_o      (fifo_push),
    .word_o      (pack_word),
    .cnt_o       (pack_cnt),
    .byte_acc_o  (byte_acc),
    .drop_o      (byte_drop)
  );

  rx_stale_timer #(.STALE_TO(STALE_TO), .XLEN_W(XLEN_W)) u_tmr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (rx_clr),
    .byte_acc_i  (byte_acc),
    .nonempty_i  (pack_cnt != 3'd0),
    .xlen_i      (xlen_q),
    .xlen_wr_i   (xlen_wr),
    .stale_evt_o (tmr_evt)
  );

  rx_word_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(32)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (rx_clr),
    .push_i  (fifo_push),
    .wdata_i (pack_word),
    .pop_i   (fifo_pop),
    .rdata_o (fifo_rdata),
    .empty_o (fifo_empty),
    .full_o  (fifo_full),
    .level_o (fifo_level)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      overrun_q <= 1'b0;
      stale_q   <= 1'b0;
      xlen_q    <= '0;
    end else begin
      if (byte_drop)    overrun_q <= 1'b1;
      else if (err_clr) overrun_q <= 1'b0;
      if (stale_evt)      stale_q <= 1'b1;
      else if (stale_clr) stale_q <= 1'b0;
      if (xlen_wr) xlen_q <= reg_wdata_i[XLEN_W-1:0];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_DATA: reg_rdata_o = fifo_empty ? 32'd0 : fifo_rdata;
      REG_STAT: begin
        reg_rdata_o[ST_READY] = !fifo_empty;
        reg_rdata_o[ST_OVR]   = overrun_q;
        reg_rdata_o[ST_STALE] = stale_q;
      end
      REG_FILL: reg_rdata_o[FILL_LSB +: 3] = pack_cnt;
      REG_XLEN: reg_rdata_o[XLEN_W-1:0] = xlen_q;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/uart_rx_word_packer_chk.sv
`timescale 1ns/1ps
module uart_rx_word_packer_chk #(
  parameter int unsigned FIFO_DEPTH = 8,
  localparam int unsigned LW = $clog2(FIFO_DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          push,
  input logic          pop,
  input logic          full,
  input logic [LW-1:0] level,
  input logic [2:0]    cnt,
  input logic          rx_clr,
  input logic          drop,
  input logic          ovr,
  input logic          err_clr,
  input logic          stale,
  input logic          stale_clr,
  input logic          stale_evt
);
  a_r3_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni) cnt <= 3'd4);
  a_r11_level_range: assert property (@(posedge clk_i) disable iff (!rst_ni) level <= LW'(FIFO_DEPTH));
  a_r8_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni) push |-> !full);
  a_r1_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && !pop && !rx_clr) |=> (32'(level) == 32'($past(level)) + 1));
  a_r9_rx_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_clr |=> (cnt == 3'd0 && level == '0));
  a_r8_ovr_set: assert property (@(posedge clk_i) disable iff (!rst_ni) drop |=> ovr);
  a_r8_ovr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni) (ovr && !err_clr) |=> ovr);
  a_r7_stale_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stale_clr && !stale_evt) |=> !stale);
endmodule

bind uart_rx_word_packer uart_rx_word_packer_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .push      (fifo_push),
  .pop       (fifo_pop),
  .full      (fifo_full),
  .level     (fifo_level),
  .cnt       (pack_cnt),
  .rx_clr    (rx_clr),
  .drop      (byte_drop),
  .ovr       (overrun_q),
  .err_clr   (err_clr),
  .stale     (stale_q),
  .stale_clr (stale_clr),
  .stale_evt (stale_evt)
);

// File: tb/uart_rx_word_packer_test.sv
`timescale 1ns/1ps
module uart_rx_word_packer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  int total = 0, bad = 0;
  logic [7:0] q[$];

  always #10 clk = ~clk;

  uart_rx_word_packer uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .reg_we_i(reg_we), .reg_re_i(reg_re), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
  );

  // tasks start and end at a falling edge
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; reg_re = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input int gap);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_word(input int base);
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++)
      if (base + k < q.size()) w[8*k +: 8] = q[base + k];
    return w;
  endfunction

  task automatic expect_word(input logic [31:0] e, input string req);
    logic [31:0] d;
    rd(3'd0, d);
    chk(d == e, req, d, e);
  endtask

  task automatic fill_is(input int n, input string req);
    logic [31:0] d;
    rd(3'd2, d);
    chk(d == (32'(n) << 7), req, d, 32'(n) << 7);
  endtask

  task automatic stat_bit(input int bitn, input bit v, input string req);
    logic [31:0] d;
    rd(3'd1, d);
    chk(d[bitn] == v, req, {31'd0, d[bitn]}, {31'd0, v});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(3'd1, d); chk(d == 0, "R2 R7 R8 reset status", d, 0);
    fill_is(0, "R3 reset fill");
    rd(3'd4, d); chk(d == 0, "R6 reset xlen", d, 0);
    rd(3'd0, d); chk(d == 0, "R2 empty read", d, 0);
    stat_bit(0, 0, "R2 empty read no pop");

    // partial word, ignored command, forced flush
    q.delete(); q.push_back(8'hA1); q.push_back(8'hB2);
    send(8'hA1, 0); send(8'hB2, 0);
    fill_is(2, "R3 fill two");
    wr(3'd3, 32'h200);
    fill_is(2, "R10 unknown cmd keeps fill");
    stat_bit(0, 0, "R10 unknown cmd no push");
    wr(3'd3, 32'h400);
    @(negedge clk);
    fill_is(0, "R4 fill after stale");
    expect_word(32'h0000_B2A1, "R4 zero upper bytes");
    stat_bit(5, 1, "R7 stale set");
    wr(3'd3, 32'h80);
    stat_bit(5, 0, "R7 stale cleared");

    // byte coinciding with force-stale
    send(8'h11, 0);
    rx_valid = 1'b1; rx_data = 8'h22;
    reg_addr = 3'd3; reg_wdata = 32'h400; reg_we = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; reg_we = 1'b0;
    @(negedge clk);
    fill_is(0, "R4 same-cycle fill");
    expect_word(32'h0000_2211, "R4 same-cycle byte included");
    wr(3'd3, 32'h400);
    @(negedge clk);
    stat_bit(0, 0, "R4 empty stale pushes nothing");
    wr(3'd3, 32'h80);

    // idle timeout
    send(8'h5C, 10);
    fill_is(1, "R5 no early timeout");
    repeat (10) @(negedge clk);
    stat_bit(0, 1, "R5 timeout flushed");
    expect_word(32'h0000_005C, "R5 timeout word");
    stat_bit(5, 1, "R7 stale from timeout");
    wr(3'd3, 32'h80);

    // transfer length
    wr(3'd4, 32'd6);
    rd(3'd4, d); chk(d == 6, "R6 xlen readback", d, 6);
    q.delete();
    for (int i = 0; i < 6; i++) begin q.push_back(8'(8'h60 + i)); send(8'(8'h60 + i), 0); end
    @(negedge clk);
    fill_is(0, "R6 length flush");
    expect_word(exp_word(0), "R1 R6 first word");
    expect_word(exp_word(4), "R6 partial word");
    stat_bit(5, 1, "R6 stale raised");
    wr(3'd4, 32'd0); wr(3'd3, 32'h80);

    // overrun with full fifo
    q.delete();
    for (int i = 0; i < 37; i++) begin
      if (i < 36) q.push_back(8'(i + 8'h40));
      send(8'(i + 8'h40), 0);
    end
    @(negedge clk);
    fill_is(4, "R8 held full word");
    stat_bit(4, 1, "R8 overrun set");
    for (int w = 0; w < 9; w++) expect_word(exp_word(4 * w), "R8 R11 drain order");
    stat_bit(0, 0, "R11 drained");
    stat_bit(4, 1, "R8 overrun sticky");
    wr(3'd3, 32'h30);
    stat_bit(4, 0, "R8 overrun cleared");
    wr(3'd3, 32'h80);

    // receiver reset
    for (int i = 0; i < 6; i++) send(8'(i), 0);
    @(negedge clk);
    wr(3'd3, 32'h10);
    fill_is(0, "R9 buffer emptied");
    stat_bit(0, 0, "R9 fifo emptied");
    rd(3'd0, d); chk(d == 0, "R9 data empty", d, 0);
    q.delete();
    for (int i = 0; i < 4; i++) begin q.push_back(8'(8'hC0 + i)); send(8'(8'hC0 + i), 0); end
    @(negedge clk);
    expect_word(exp_word(0), "R9 R1 after reset");

    // random bursts
    for (int it = 0; it < 20; it++) begin
      int n = $urandom_range(1, 28);
      q.delete();
      for (int i = 0; i < n; i++) begin
        logic [7:0] b = 8'($urandom);
        q.push_back(b);
        send(b, $urandom_range(0, 3));
      end
      @(negedge clk);
      fill_is(n % 4, "R3 random fill");
      wr(3'd3, 32'h400);
      @(negedge clk);
      stat_bit(0, 1, "R2 random ready");
      for (int w = 0; w < (n + 3) / 4; w++) expect_word(exp_word(4 * w), "R1 random word");
      stat_bit(0, 0, "R2 random empty");
      wr(3'd3, 32'h80);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule